// File: doc/BRIEF.md
# Asynchronous Registered Logic Macrocell

This block is one output cell of a small programmable logic array. Four data product-term values are ORed into a single sum. That sum either drives the pin directly (combinatorial mode) or is captured by a flip-flop. The flip-flop has its own clock, set and clear product terms, so every cell runs on a private clock. A per-cell polarity bit can invert the pin level. The pin is enabled only when the cell's enable product term is true and a shared active-low enable input is low. A feedback bit goes back to the array. It carries the cell's internal state while the cell drives, and the pin level while the cell is used as an input.

The block is modelled on a system clock `clk`. The clock product term is edge-detected against `clk`. Set and clear act on the output at once, without waiting for an edge of the clock term, and they are latched into the register at the next `clk` edge. A test preload input loads the register from the pin level. An active-low reset clears the register at power-up. Every control here is a plain level pin; no data streams in or out, so the block has no valid/ready handshake.

Top module: `arlm_macrocell`

## Requirements
- R1: While `rst_n` is low the register is 0, so a registered cell with `cfg_active_low`=1 shows `pad_o`=1.
- R2: The data sum is the OR of all bits of `pt_data`. With `cfg_comb`=1, `pad_o` follows that sum in the same cycle.
- R3: With `cfg_comb`=0 the register takes the data sum at the `clk` edge where `pt_clk` is first seen high after being low. At all other times it holds its value.
- R4: `cfg_active_low`=1 inverts `pad_o` in both modes: `pad_o` = core ^ `cfg_active_low`.
- R5: `pt_set` high forces the cell state to 1 before any edge, and the register holds 1 after `pt_set` is released.
- R6: `pt_rst` high forces the cell state to 0 before any edge, and it wins when `pt_set` is also high.
- R7: After set or clear is released, the register changes only at a new rising edge of the clock term. A clock-term edge seen while clear is high is discarded.
- R8: `preload_n` low loads `pad_i ^ cfg_active_low` at the next `clk` edge, so the pin then shows the level that was applied. Preload outranks the clock term and is outranked by set and clear.
- R9: `pad_oe` = `pt_oe` AND NOT `oe_n`.
- R10: `fb_o` equals `pad_i` when `pad_oe` is 0. When `pad_oe` is 1 it equals the core value before polarity: the register state in registered mode, the data sum in combinatorial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the clock product term |
| rst_n | input | 1 | Asynchronous active-low power-up clear |
| pt_data | input | N_DATA | Data product-term values |
| pt_clk | input | 1 | Clock product term |
| pt_set | input | 1 | Set product term |
| pt_rst | input | 1 | Clear product term |
| pt_oe | input | 1 | Enable product term |
| oe_n | input | 1 | Shared external enable, active low |
| cfg_comb | input | 1 | 1 selects combinatorial mode |
| cfg_active_low | input | 1 | 1 inverts the pin level |
| preload_n | input | 1 | Active-low test preload strobe |
| pad_i | input | 1 | Level present on the pin |
| pad_o | output | 1 | Level the cell drives onto the pin |
| pad_oe | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback bit to the array |

## Verification
The in-line properties check the ranking of the register's load sources on every `clk` edge: clear over set over preload over clock. They also check that the register never moves without a trigger, that the edge detector never fires twice in a row, and that clear reaches the pin with no edge. Only the bench's scenarios show the full behaviour. These scenarios are the four mode combinations seen at the pin, an edge being discarded during clear, a preload that loads through an inverted pin, the output-enable gating, and the feedback source switching when the cell turns into an input.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int unsigned DEF_DATA_TERMS = 4;

  typedef struct packed {
    logic comb;
    logic active_low;
  } cell_cfg_t;

  function automatic logic apply_pol(input logic v, input logic inv);
    return v ^ inv;
  endfunction
endpackage

// File: rtl/mcell_sum.sv
module mcell_sum #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] terms,
  output logic         sum
);
  logic [N-1:0] chain;

  assign chain[0] = terms[0];
  for (genvar i = 1; i < N; i++) begin : g_or
    assign chain[i] = chain[i-1] | terms[i];
  end
  assign sum = chain[N-1];
endmodule

// File: rtl/mcell_edge.sv
module mcell_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic term,
  output logic rise
);
  logic prev_q;

  // prev resets high so a term already high at release is not taken as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= term;
  end

  assign rise = term & ~prev_q;

  // R3
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/mcell_state.sv
module mcell_state (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic rise,
  input  logic set_t,
  input  logic clr_t,
  input  logic pl_n,
  input  logic pl_d,
  output logic q_eff
);
  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= 1'b0;
    else if (clr_t)  q_r <= 1'b0;
    else if (set_t)  q_r <= 1'b1;
    else if (!pl_n)  q_r <= pl_d;
    else if (rise)   q_r <= d;
  end

  // set and clear reach the output without waiting for an edge
  always_comb begin
    if (clr_t)      q_eff = 1'b0;
    else if (set_t) q_eff = 1'b1;
    else            q_eff = q_r;
  end

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_t |=> !q_r);
  // R5
  set_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_t && !clr_t) |=> q_r);
  // R8
  preload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_n && !set_t && !clr_t) |=> (q_r == $past(pl_d)));
  // R7
  hold_no_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && pl_n && !set_t && !clr_t) |=> $stable(q_r));
endmodule

// File: rtl/mcell_out.sv
module mcell_out
  import mcell_pkg::*;
(
  input  cell_cfg_t cfg,
  input  logic      sum,
  input  logic      q_eff,
  input  logic      pt_oe,
  input  logic      oe_n,
  input  logic      pad_i,
  output logic      pad_o,
  output logic      pad_oe,
  output logic      fb_o
);
  logic core;

  assign core   = cfg.comb ? sum : q_eff;
  assign pad_o  = apply_pol(core, cfg.active_low);
  assign pad_oe = pt_oe & ~oe_n;
  assign fb_o   = pad_oe ? core : pad_i;
endmodule

// File: rtl/arlm_macrocell.sv
module arlm_macrocell
  import mcell_pkg::*;
#(
  parameter int unsigned N_DATA = DEF_DATA_TERMS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DATA-1:0] pt_data,
  input  logic              pt_clk,
  input  logic              pt_set,
  input  logic              pt_rst,
  input  logic              pt_oe,
  input  logic              oe_n,
  input  logic              cfg_comb,
  input  logic              cfg_active_low,
  input  logic              preload_n,
  input  logic              pad_i,
  output logic              pad_o,
  output logic              pad_oe,
  output logic              fb_o
);
  cell_cfg_t cfg;
  logic      sum;
  logic      rise;
  logic      q_eff;
  logic      pl_d;

  assign cfg.comb       = cfg_comb;
  assign cfg.active_low = cfg_active_low;
  // pin level maps back through polarity so the pin keeps the applied level
  assign pl_d           = pad_i ^ cfg_active_low;

  mcell_sum #(.N(N_DATA)) u_sum (
    .terms (pt_data),
    .sum   (sum)
  );

  mcell_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .term  (pt_clk),
    .rise  (rise)
  );

  mcell_state u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sum),
    .rise  (rise),
    .set_t (pt_set),
    .clr_t (pt_rst),
    .pl_n  (preload_n),
    .pl_d  (pl_d),
    .q_eff (q_eff)
  );

  mcell_out u_out (
    .cfg    (cfg),
    .sum    (sum),
    .q_eff  (q_eff),
    .pt_oe  (pt_oe),
    .oe_n   (oe_n),
    .pad_i  (pad_i),
    .pad_o  (pad_o),
    .pad_oe (pad_oe),
    .fb_o   (fb_o)
  );

  // R6
  clear_at_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_comb && pt_rst) |-> (pad_o == cfg_active_low));
  // R9
  ext_enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !pad_oe);
endmodule

// File: tb/arlm_macrocell_bench.sv
module arlm_macrocell_bench;
  typedef struct {
    string tag;
    logic  pad;
    logic  oe;
    logic  fb;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pt_data = '0;
  logic       pt_clk = 1'b0, pt_set = 1'b0, pt_rst = 1'b0, pt_oe = 1'b1;
  logic       oe_n = 1'b0, cfg_comb = 1'b0, cfg_active_low = 1'b0;
  logic       preload_n = 1'b1, pad_i = 1'b0;
  logic       pad_o, pad_oe, fb_o;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  logic mq = 1'b0;
  logic mprev = 1'b1;

  always #4 clk = ~clk;

  arlm_macrocell u_arlm_macrocell (
    .clk(clk), .rst_n(rst_n), .pt_data(pt_data), .pt_clk(pt_clk),
    .pt_set(pt_set), .pt_rst(pt_rst), .pt_oe(pt_oe), .oe_n(oe_n),
    .cfg_comb(cfg_comb), .cfg_active_low(cfg_active_low),
    .preload_n(preload_n), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .fb_o(fb_o)
  );

  // monitor: one expected item per cycle, compared after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (pad_o !== e.pad || pad_oe !== e.oe || fb_o !== e.fb) begin
          n_errors++;
          $display("FAIL %s: pad_o/pad_oe/fb_o = %b%b%b expected %b%b%b",
                   e.tag, pad_o, pad_oe, fb_o, e.pad, e.oe, e.fb);
        end
      end
    end
  end

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic cyc(input string tag, input logic rst, input logic [3:0] d,
                     input logic ck, input logic st, input logic rs,
                     input logic oet, input logic oen, input logic cm,
                     input logic al, input logic pln, input logic pi,
                     input logic probe);
    logic sum, eff, core, oe;
    exp_t e;
    @(negedge clk);
    rst_n = ~rst; pt_data = d; pt_clk = ck; pt_set = st; pt_rst = rs;
    pt_oe = oet; oe_n = oen; cfg_comb = cm; cfg_active_low = al;
    preload_n = pln; pad_i = pi;
    sum = |d;
    oe  = oet & ~oen;
    if (probe) begin
      // set/clear must be visible before any edge
      #1;
      eff  = rst ? 1'b0 : rs ? 1'b0 : st ? 1'b1 : mq;
      core = cm ? sum : eff;
      n_checks++;
      if (pad_o !== (core ^ al)) begin
        n_errors++;
        $display("FAIL %s (before edge): pad_o=%b expected %b", tag, pad_o, core ^ al);
      end
    end
    if (rst) begin
      mq = 1'b0; mprev = 1'b1;
    end else begin
      if (rs)        mq = 1'b0;
      else if (st)   mq = 1'b1;
      else if (!pln) mq = pi ^ al;
      else if (ck && !mprev) mq = sum;
      mprev = ck;
    end
    core  = cm ? sum : mq;
    e.tag = tag;
    e.pad = core ^ al;
    e.oe  = oe;
    e.fb  = oe ? core : pi;
    sb.push_back(e);
  endtask

  // watchdog
  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    //   tag    rst d       ck st rs oet oen cm al pln pi probe
    // R1 reset state, active-low registered
    cyc("R1", 1, 4'b0000, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0);
    cyc("R1", 0, 4'b0000, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0);
    // R2 combinatorial OR, active high
    cyc("R2", 0, 4'b0000, 0, 0, 0, 1, 0, 1, 0, 1, 0, 0);
    cyc("R2", 0, 4'b0100, 0, 0, 0, 1, 0, 1, 0, 1, 0, 0);
    cyc("R2", 0, 4'b1000, 0, 0, 0, 1, 0, 1, 0, 1, 0, 0);
    // R4 combinatorial active low
    cyc("R4", 0, 4'b0001, 0, 0, 0, 1, 0, 1, 1, 1, 0, 0);
    cyc("R4", 0, 4'b0000, 0, 0, 0, 1, 0, 1, 1, 1, 0, 0);
    // R3 registered, active high: capture only on clock-term rise
    cyc("R3", 0, 4'b0010, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    cyc("R3", 0, 4'b0010, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    cyc("R3", 0, 4'b0000, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    cyc("R3", 0, 4'b0000, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    cyc("R3", 0, 4'b0000, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    // R4 registered, active low
    cyc("R4", 0, 4'b1111, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0);
    cyc("R4", 0, 4'b1111, 1, 0, 0, 1, 0, 0, 1, 1, 0, 0);
    // R6 clear seen before the edge, then held
    cyc("R6", 0, 4'b0000, 0, 0, 1, 1, 0, 0, 0, 1, 0, 1);
    cyc("R6", 0, 4'b0000, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    // R5 set seen before the edge, then held
    cyc("R5", 0, 4'b0000, 0, 1, 0, 1, 0, 0, 0, 1, 0, 1);
    cyc("R5", 0, 4'b0000, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    // R6 clear beats set
    cyc("R6", 0, 4'b0000, 0, 1, 1, 1, 0, 0, 0, 1, 0, 1);
    // R7 edge during clear discarded, recovery on next fresh edge
    cyc("R7", 0, 4'b0001, 1, 0, 1, 1, 0, 0, 0, 1, 0, 0);
    cyc("R7", 0, 4'b0001, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    cyc("R7", 0, 4'b0001, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    cyc("R7", 0, 4'b0001, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    // R8 preload from pin with driver off, active high
    cyc("R8", 0, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 0, 4'b0000, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    // R8 preload through active-low: pin keeps applied level
    cyc("R8", 0, 4'b0000, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0);
    cyc("R8", 0, 4'b0000, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0);
    // R8 preload outranks a clock-term edge
    cyc("R8", 0, 4'b1111, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    cyc("R8", 0, 4'b1111, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R8 set outranks preload
    cyc("R8", 0, 4'b0000, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    // R9 enable gating
    cyc("R9", 0, 4'b0000, 0, 0, 0, 1, 1, 0, 0, 1, 0, 0);
    cyc("R9", 0, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R9", 0, 4'b0000, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    // R10 feedback: pin when input, sum in combinatorial mode
    cyc("R10", 0, 4'b0000, 0, 0, 0, 1, 1, 0, 0, 1, 1, 0);
    cyc("R10", 0, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R10", 0, 4'b0110, 0, 0, 0, 1, 0, 1, 1, 1, 0, 0);
    // R1 reset again mid-run clears a set register
    cyc("R1", 0, 4'b0000, 0, 1, 0, 1, 0, 0, 1, 1, 0, 0);
    cyc("R1", 1, 4'b0000, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0);
    cyc("R1", 0, 4'b0000, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0);
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule